// File: doc/BRIEF.md
# Mask-Programmed DRAM Address Mapper

This block turns a 40-bit physical address into the row, column and bank fields that a memory controller sends to an SDRAM device. Each chip select has three programmable 40-bit masks: one for the row, one for the column and one for the bank. Every set bit in a mask selects the address bit at the same position. The selected bits are packed densely, with the lowest set bit becoming bit 0 of the field. Address bits [4:3] always supply the two lowest column bits. The column mask may set bit 5 alone, or bits [6:5], apart from its main run. This lets consecutive 64-byte or 128-byte blocks fall into different banks.

A bank mask with exactly three set bits marks an eight-bank device. The third bank bit is then driven onto the device's top address pin, in both the row and the column words, and a flag reports that this is happening. A request enters with a chip select number and a valid flag. One clock later the translated fields appear, registered, together with the same chip select and valid. A configuration-error flag is raised when the selected chip select's masks overlap, or when a mask breaks the contiguity rule. The translation is still produced in that case.

Top module: `dram_addr_mapper`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, out_valid is 0 and out_row, out_col, out_bank, out_xbank and out_cfg_err are all 0.
- R2: out_row packs the address bits selected by the row mask, lowest set bit first. For example, mask bits 26..15 give out_row[11:0] = addr[26:15].
- R3: out_col[1:0] always equals addr[4:3], whether or not the column mask sets bits 4 or 3. The remaining selected bits follow from out_col[2] upward, lowest first.
- R4: A column mask with bit 5 set plus a run on bits 14..8 gives out_col = {addr[14:8], addr[5], addr[4:3]}. This is the 64-byte interleave.
- R5: A column mask with bits 6:5 set plus a run on bits 15..10 gives out_col[9:0] = {addr[15:10], addr[6:5], addr[4:3]}. This is the 128-byte interleave.
- R6: A bank mask with two set bits drives out_bank[1:0] with those bits, lowest first. In that case out_bank[2] and out_xbank are 0.
- R7: A bank mask with exactly three set bits drives all three onto out_bank[2:0] and sets out_xbank. out_bank[2] is then also placed on bit TOP_PIN (default 12) of both out_row and out_col.
- R8: Field bits above the number of set mask bits are 0, unless R7 places the third bank bit there.
- R9: Each chip select uses only its own masks, and out_cs repeats the chip select of the request.
- R10: out_valid equals in_valid of the previous cycle, and the translated fields belong to that request.
- R11: A mask write (cfg_sel 0 = row, 1 = column, 2 = bank) is used from the next cycle on. A request made in the same cycle as the write is translated with the old mask.
- R12: out_cfg_err is 1 when the masks of the selected chip select overlap, counting column bits 4:3 as always present. It is also 1 when a mask has a gap, with the column mask's allowed bit-5 and bits-6:5 splits excepted. The fields are still translated as R2 to R7 describe.
- R13: out_cfg_err is 0 for legal, non-overlapping masks, including the two split column forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_cs | input | CSW | Chip select whose mask is written |
| cfg_sel | input | 2 | Mask chosen: 0 row, 1 column, 2 bank |
| cfg_data | input | 40 | Mask value to write |
| in_valid | input | 1 | Request valid |
| in_cs | input | CSW | Chip select of the request |
| in_addr | input | 40 | Physical address of the request |
| out_valid | output | 1 | Translated result valid |
| out_cs | output | CSW | Chip select of the result |
| out_row | output | 15 | Packed row address |
| out_col | output | 15 | Packed column address |
| out_bank | output | 3 | Packed bank address |
| out_xbank | output | 1 | Third bank bit is in use on the top pin |
| out_cfg_err | output | 1 | Masks of this chip select overlap or have a gap |

## Verification
Each result is due exactly one clock edge after its request. The bench drives a request on a falling edge and compares every output field on the next falling edge. By then exactly one rising edge has captured the translation into the output registers.

A mask write takes effect after one rising edge. For R11, the bench drives a request and a write to the same mask on the same falling edge. It expects the old mapping on the next falling edge, and the new mapping one request later.

Expected fields are built in the bench from fixed bit slices for each configuration. No general mask-packing routine is used to compute them.

// File: rtl/dam_pkg.sv
package dam_pkg;

    localparam int ADDR_W    = 40;
    localparam int FIELD_W   = 15;
    localparam int BANK_W    = 3;
    localparam int COL_LO    = 3;   // address bits [4:3] are fixed low column bits
    localparam int SPLIT_LO  = 5;   // optional split column bits start here
    localparam logic [ADDR_W-1:0] FIXED_COL = 40'h18;

    typedef enum logic [1:0] {
        SEL_ROW  = 2'd0,
        SEL_COL  = 2'd1,
        SEL_BANK = 2'd2
    } mask_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic [ADDR_W-1:0] bank;
    } mask_set_t;

    typedef struct packed {
        logic [FIELD_W-1:0] row;
        logic [FIELD_W-1:0] col;
        logic [BANK_W-1:0]  bank;
        logic               xbank;
        logic               err;
    } xlate_t;

    // Collect the address bits picked by mask m, lowest set bit first.
    function automatic logic [FIELD_W-1:0] gather(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] m);
        logic [FIELD_W-1:0] r;
        int k;
        r = '0;
        k = 0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (m[i]) begin
                if (k < FIELD_W) r[k] = a[i];
                k++;
            end
        end
        return r;
    endfunction

    // True when the set bits of m form one unbroken run (or m is empty).
    function automatic logic is_run(input logic [ADDR_W-1:0] m);
        logic [ADDR_W-1:0] low;
        low = m & (~m + 40'd1);
        return ((m + low) & m) == '0;
    endfunction

    // Column mask with the fixed low bits and the permitted split removed.
    function automatic logic [ADDR_W-1:0] col_core(input logic [ADDR_W-1:0] m);
        logic [ADDR_W-1:0] c;
        c = m & ~FIXED_COL;
        if (c[SPLIT_LO]) begin
            c[SPLIT_LO]   = 1'b0;
            c[SPLIT_LO+1] = 1'b0;
        end
        return c;
    endfunction

endpackage

// File: rtl/dam_mask_store.sv
module dam_mask_store
    import dam_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CSW    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CSW-1:0]    wr_cs,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [CSW-1:0]    rd_cs,
    output mask_set_t         rd_masks
);

    mask_set_t bank_q [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[g] <= '0;
            end else if (we && (int'(wr_cs) == g)) begin
                case (mask_sel_e'(wr_sel))
                    SEL_ROW:  bank_q[g].row  <= wr_data;
                    SEL_COL:  bank_q[g].col  <= wr_data;
                    SEL_BANK: bank_q[g].bank <= wr_data;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        rd_masks = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (int'(rd_cs) == i) rd_masks = bank_q[i];
        end
    end

endmodule

// File: rtl/dam_extract.sv
module dam_extract
    import dam_pkg::*;
#(
    parameter int TOP_PIN = 12
) (
    input  logic [ADDR_W-1:0]  addr,
    input  mask_set_t          masks,
    output logic [FIELD_W-1:0] row,
    output logic [FIELD_W-1:0] col,
    output logic [BANK_W-1:0]  bank,
    output logic               xbank
);

    logic [FIELD_W-1:0] row_raw;
    logic [FIELD_W-1:0] col_body;
    logic [FIELD_W-1:0] bank_raw;

    always_comb begin
        row_raw  = gather(addr, masks.row);
        col_body = gather(addr, masks.col & ~FIXED_COL);
        bank_raw = gather(addr, masks.bank);
        xbank    = ($countones(masks.bank) == BANK_W);

        bank = xbank ? bank_raw[BANK_W-1:0] : {1'b0, bank_raw[BANK_W-2:0]};
        row  = row_raw;
        col  = {col_body[FIELD_W-3:0], addr[COL_LO+1:COL_LO]};
        if (xbank) begin
            row[TOP_PIN] = bank[BANK_W-1];
            col[TOP_PIN] = bank[BANK_W-1];
        end
    end

endmodule

// File: rtl/dam_mask_audit.sv
module dam_mask_audit
    import dam_pkg::*;
(
    input  mask_set_t masks,
    output logic      bad
);

    logic [ADDR_W-1:0] col_all;
    logic              overlap;
    logic              gap;

    always_comb begin
        col_all = masks.col | FIXED_COL;
        overlap = |((masks.row & col_all) | (masks.row & masks.bank) |
                    (col_all & masks.bank));
        gap     = !is_run(masks.row) || !is_run(masks.bank) ||
                  !is_run(col_core(masks.col));
        bad     = overlap || gap;
    end

endmodule

// File: rtl/dram_addr_mapper.sv
module dram_addr_mapper
    import dam_pkg::*;
#(
    parameter  int NUM_CS  = 4,
    parameter  int TOP_PIN = 12,
    localparam int CSW     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CSW-1:0]     cfg_cs,
    input  logic [1:0]         cfg_sel,
    input  logic [ADDR_W-1:0]  cfg_data,
    input  logic               in_valid,
    input  logic [CSW-1:0]     in_cs,
    input  logic [ADDR_W-1:0]  in_addr,
    output logic               out_valid,
    output logic [CSW-1:0]     out_cs,
    output logic [FIELD_W-1:0] out_row,
    output logic [FIELD_W-1:0] out_col,
    output logic [BANK_W-1:0]  out_bank,
    output logic               out_xbank,
    output logic               out_cfg_err
);

    mask_set_t cur_masks;
    xlate_t    nxt;
    xlate_t    res_q;
    logic      vld_q;
    logic [CSW-1:0] cs_q;

    dam_mask_store #(.NUM_CS(NUM_CS), .CSW(CSW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wr_cs   (cfg_cs),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_data),
        .rd_cs   (in_cs),
        .rd_masks(cur_masks)
    );

    dam_extract #(.TOP_PIN(TOP_PIN)) u_extract (
        .addr (in_addr),
        .masks(cur_masks),
        .row  (nxt.row),
        .col  (nxt.col),
        .bank (nxt.bank),
        .xbank(nxt.xbank)
    );

    dam_mask_audit u_audit (
        .masks(cur_masks),
        .bad  (nxt.err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            cs_q  <= '0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                cs_q  <= in_cs;
                res_q <= nxt;
            end
        end
    end

    assign out_valid   = vld_q;
    assign out_cs      = cs_q;
    assign out_row     = res_q.row;
    assign out_col     = res_q.col;
    assign out_bank    = res_q.bank;
    assign out_xbank   = res_q.xbank;
    assign out_cfg_err = res_q.err;

endmodule

// File: rtl/dam_checker.sv
module dam_checker
    import dam_pkg::*;
#(
    parameter int CSW     = 2,
    parameter int TOP_PIN = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [CSW-1:0]     in_cs,
    input logic [ADDR_W-1:0]  in_addr,
    input logic               out_valid,
    input logic [CSW-1:0]     out_cs,
    input logic [FIELD_W-1:0] out_row,
    input logic [FIELD_W-1:0] out_col,
    input logic [BANK_W-1:0]  out_bank,
    input logic               out_xbank
);

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

    p_valid_follow_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_cs_echo_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_cs == $past(in_cs));

    p_col_low_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_col[1:0] == $past(in_addr[COL_LO+1:COL_LO]));

    p_bank_narrow_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_xbank) |-> !out_bank[BANK_W-1]);

    p_top_pin_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_xbank) |->
            (out_row[TOP_PIN] == out_bank[BANK_W-1]) &&
            (out_col[TOP_PIN] == out_bank[BANK_W-1]));

endmodule

bind dram_addr_mapper dam_checker #(.CSW(CSW), .TOP_PIN(TOP_PIN)) u_dam_checker (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_cs    (in_cs),
    .in_addr  (in_addr),
    .out_valid(out_valid),
    .out_cs   (out_cs),
    .out_row  (out_row),
    .out_col  (out_col),
    .out_bank (out_bank),
    .out_xbank(out_xbank)
);

// File: tb/dram_addr_mapper_bench.sv
`timescale 1ns/1ps
module dram_addr_mapper_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_cs = '0;
    logic [1:0]  cfg_sel = '0;
    logic [39:0] cfg_data = '0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_cs = '0;
    logic [39:0] in_addr = '0;
    logic        out_valid;
    logic [1:0]  out_cs;
    logic [14:0] out_row;
    logic [14:0] out_col;
    logic [2:0]  out_bank;
    logic        out_xbank;
    logic        out_cfg_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    dram_addr_mapper u_dram_addr_mapper (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_cs(in_cs), .in_addr(in_addr),
        .out_valid(out_valid), .out_cs(out_cs), .out_row(out_row),
        .out_col(out_col), .out_bank(out_bank), .out_xbank(out_xbank),
        .out_cfg_err(out_cfg_err)
    );

    // mask values for the configurations
    localparam logic [39:0] A_ROW  = 40'hFFF << 15;
    localparam logic [39:0] A_COL  = 40'hFF << 7;
    localparam logic [39:0] A_BANK = 40'h3 << 5;
    localparam logic [39:0] B_COL  = (40'h7F << 8) | (40'h1 << 5);
    localparam logic [39:0] B_BANK = 40'h3 << 6;
    localparam logic [39:0] C_ROW  = 40'hFFF << 16;
    localparam logic [39:0] C_COL  = (40'h3F << 10) | (40'h3 << 5) | 40'h18;
    localparam logic [39:0] C_BANK = 40'h7 << 7;
    localparam logic [39:0] D_ROW  = A_ROW | (40'h1 << 30);
    localparam logic [39:0] E_BANK = 40'h3 << 7;

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int cs, input int sel, input logic [39:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_cs = cs[1:0]; cfg_sel = sel[1:0]; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // cfg: 0 plain, 1 64B split, 2 128B split + 8 banks, 3 gap in row, 4 overlap
    task automatic expect_map(input int cfg, input logic [39:0] a,
                              output logic [14:0] er, output logic [14:0] ec,
                              output logic [2:0] eb, output logic ex, output logic ee);
        er = {3'b0, a[26:15]};
        ec = {5'b0, a[14:7], a[4:3]};
        eb = {1'b0, a[6:5]};
        ex = 1'b0;
        ee = 1'b0;
        case (cfg)
            1: begin
                ec = {5'b0, a[14:8], a[5], a[4:3]};
                eb = {1'b0, a[7:6]};
            end
            2: begin
                er = {2'b0, a[9], a[27:16]};
                ec = {2'b0, a[9], 2'b0, a[15:10], a[6:5], a[4:3]};
                eb = a[9:7];
                ex = 1'b1;
            end
            3: begin
                er = {2'b0, a[30], a[26:15]};
                ee = 1'b1;
            end
            4: begin
                eb = {1'b0, a[8:7]};
                ee = 1'b1;
            end
            default: ;
        endcase
    endtask

    task automatic xl(input int cs, input int cfg, input logic [39:0] a);
        logic [14:0] er, ec;
        logic [2:0]  eb;
        logic        ex, ee;
        string rc, rb, re;
        expect_map(cfg, a, er, ec, eb, ex, ee);
        rc = (cfg == 1) ? "R4 col" : (cfg == 2) ? "R5 col" : "R3 col";
        rb = (cfg == 2) ? "R7 bank" : "R6 bank";
        re = (cfg >= 3) ? "R12 cfg_err" : "R13 cfg_err";
        @(negedge clk);
        in_valid = 1'b1; in_cs = cs[1:0]; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 out_valid", {39'b0, out_valid}, 40'd1);
        chk("R9 out_cs", {38'b0, out_cs}, cs);
        chk("R2 row", {25'b0, out_row}, {25'b0, er});
        chk(rc, {25'b0, out_col}, {25'b0, ec});
        chk(rb, {37'b0, out_bank}, {37'b0, eb});
        chk("R7 xbank", {39'b0, out_xbank}, {39'b0, ex});
        chk(re, {39'b0, out_cfg_err}, {39'b0, ee});
        chk("R8 upper zero", {36'b0, out_row[14:13], out_col[14:13]},
            {36'b0, er[14:13], ec[14:13]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [39:0] a;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 valid in reset", {39'b0, out_valid}, 40'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid", {39'b0, out_valid}, 40'd0);
        chk("R1 row", {25'b0, out_row}, 40'd0);
        chk("R1 col", {25'b0, out_col}, 40'd0);
        chk("R1 bank", {36'b0, out_bank, out_xbank}, 40'd0);
        chk("R1 cfg_err", {39'b0, out_cfg_err}, 40'd0);

        wr(0, 0, A_ROW); wr(0, 1, A_COL); wr(0, 2, A_BANK);
        wr(1, 0, A_ROW); wr(1, 1, B_COL); wr(1, 2, B_BANK);
        wr(2, 0, C_ROW); wr(2, 1, C_COL); wr(2, 2, C_BANK);
        wr(3, 0, D_ROW); wr(3, 1, A_COL); wr(3, 2, A_BANK);

        @(negedge clk);
        chk("R10 idle no valid", {39'b0, out_valid}, 40'd0);

        for (int i = 0; i < 40; i++) begin
            for (int cs = 0; cs < 4; cs++) xl(cs, cs, 40'h1 << i);
        end
        for (int i = 0; i < 60; i++) begin
            a = {$urandom(), $urandom()};
            for (int cs = 0; cs < 4; cs++) xl(cs, cs, a);
        end
        for (int cs = 0; cs < 4; cs++) xl(cs, cs, '1);

        // R11: write in the same cycle as a request
        a = 40'hA5_5A3C_96E1;
        @(negedge clk);
        in_valid = 1'b1; in_cs = 2'd0; in_addr = a;
        cfg_we = 1'b1; cfg_cs = 2'd0; cfg_sel = 2'd0; cfg_data = C_ROW;
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
        chk("R11 old mask in flight", {25'b0, out_row}, {28'b0, a[26:15]});
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11 new mask used", {25'b0, out_row}, {28'b0, a[27:16]});
        wr(0, 0, A_ROW);

        // R12: overlapping bank and column on chip select 3
        wr(3, 0, A_ROW); wr(3, 2, E_BANK);
        for (int i = 0; i < 30; i++) begin
            a = {$urandom(), $urandom()};
            xl(3, 4, a);
            xl(0, 0, a);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule